// File: doc/BRIEF.md
# Parallel Bit-Flipping Parity-Check Decoder

This block corrects hard-decision channel errors in a short low-density parity-check code. A received word of bits enters on a valid strobe. It then passes through a fixed chain of unrolled decoding stages. In each stage every check computes, for each bit it covers, the value that bit would need to make the check even. Every bit then looks at the predictions for it and inverts itself only when a strict majority of them disagree with its present value. All bits of a stage update together. A stage never uses its own partly updated result.

The parity-check matrix, the number of stages and the placement of pipeline registers between stages are all elaboration-time parameters. After the last stage a final parity test reports whether the corrected word is a codeword. A small tag carried down the chain reports the earliest point at which the word already satisfied every check. A caller can use that tag to tell how much decoding effort the word needed. The block accepts one word per cycle with no stalls.

Top module: `ldpc_bf_decoder`

## Requirements
- R1: A bit is inverted by a stage exactly when more than half of the checks that contain it predict the opposite of its stage-input value. A check predicts a bit as the XOR of the other bits it covers.
- R2: When the disagreeing predictions for a bit are exactly half of its checks (a tie), the bit keeps its stage-input value.
- R3: All bits of a stage update at the same time from that stage's input word, and N_STAGES stages are applied in sequence.
- R4: A word that already satisfies every check leaves the decoder unchanged, with out_first_ok = 0.
- R5: out_syn_ok is 1 exactly when out_word satisfies every row of the matrix (the XOR of the covered bits is 0 for each row).
- R6: out_first_ok encodes the earliest valid point. 0 means the received word was a codeword. k (1..N_STAGES) means the word first became a codeword after stage k. N_STAGES+1 means it never did, which holds exactly when out_syn_ok is 0.
- R7: out_valid repeats in_valid after a latency of 1 plus the number of set bits among REG_MASK[N_STAGES-2:0]. The bit for the last stage is ignored, because the output register always follows the last stage. The block accepts one word every cycle.
- R8: A synchronous active-high reset clears out_valid, out_word, out_syn_ok and out_first_ok to 0.
- R9: Word bit i holds the (i+1)-th channel bit. With the default matrix, the received sequence 0,1,1,0,1,1 (in_word = 6'b110110) decodes to 0,0,1,0,1,1 (out_word = 6'b110100) with out_syn_ok = 1.
- R10: The default matrix has 4 checks over 6 bits, each check covering 3 bits. The checks cover the bit sets {0,1,3}, {1,2,4}, {0,4,5} and {2,3,5}. Row r is held in H_MAT[r*N_BITS +: N_BITS].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received word present this cycle |
| in_word | input | N_BITS | Received hard-decision word, bit i = channel bit i+1 |
| out_valid | output | 1 | Decoded result present |
| out_word | output | N_BITS | Corrected word |
| out_syn_ok | output | 1 | Corrected word satisfies every check |
| out_first_ok | output | $clog2(N_STAGES+2) | Earliest stage count after which the word was a codeword |

## Verification
The bench builds two copies side by side from one input stream. The first uses the default two stages with both registered, giving a latency of 2 and a 2-bit tag. The second has three stages with no register between them, so the whole chain is combinational into the output register, the latency is 1, and the 3-bit tag can report a word that becomes valid only after the third stage. Running both against one reference model exercises the register-mask latency rule, the tie-keeping rule on double errors, and words that never settle.

// File: rtl/ldpc_bf_pkg.sv
package ldpc_bf_pkg;

  // Default code: 6 bits, 4 checks of weight 3, each bit in 2 checks.
  localparam int DEF_N_BITS   = 6;
  localparam int DEF_N_CHECKS = 4;

  // Row r lives in bits [r*6 +: 6]; bit i of a row marks word bit i.
  localparam logic [DEF_N_CHECKS*DEF_N_BITS-1:0] DEF_H_MAT = {
    6'b101100,   // check 3: bits 2,3,5
    6'b110001,   // check 2: bits 0,4,5
    6'b010110,   // check 1: bits 1,2,4
    6'b001011    // check 0: bits 0,1,3
  };

  localparam int DEF_N_STAGES = 2;

endpackage

// File: rtl/ldpc_check_node.sv
module ldpc_check_node #(
  parameter int              N_BITS = 6,
  parameter logic [N_BITS-1:0] ROW  = '1
)(
  input  logic [N_BITS-1:0] word,
  output logic [N_BITS-1:0] pred,
  output logic              fail
);

  logic par;

  assign par  = ^(word & ROW);
  assign fail = par;

  // Value each covered bit would need so that the check sums to zero:
  // the XOR of the other covered bits, i.e. total parity with own bit removed.
  for (genvar j = 0; j < N_BITS; j++) begin : g_pred
    if (ROW[j]) begin : g_member
      assign pred[j] = par ^ word[j];
    end else begin : g_none
      assign pred[j] = 1'b0;
    end
  end

endmodule

// File: rtl/ldpc_bit_node.sv
module ldpc_bit_node #(
  parameter int                N_CHECKS = 4,
  parameter logic [N_CHECKS-1:0] COL    = '1
)(
  input  logic                cur,
  input  logic [N_CHECKS-1:0] preds,
  output logic                nxt
);

  function automatic int weight(logic [N_CHECKS-1:0] v);
    int n = 0;
    for (int r = 0; r < N_CHECKS; r++) if (v[r]) n++;
    return n;
  endfunction

  localparam int DEG  = weight(COL);
  localparam int HALF = DEG / 2;

  int against;

  always_comb begin
    against = 0;
    for (int r = 0; r < N_CHECKS; r++) begin
      if (COL[r] && (preds[r] != cur)) against = against + 1;
    end
  end

  // Strict majority flips; a tie keeps the current value.
  assign nxt = (against > HALF) ? ~cur : cur;

endmodule

// File: rtl/ldpc_syndrome.sv
module ldpc_syndrome #(
  parameter int N_BITS   = 6,
  parameter int N_CHECKS = 4,
  parameter logic [N_CHECKS*N_BITS-1:0] H_MAT = '0
)(
  input  logic [N_BITS-1:0] word,
  output logic              zero
);

  logic [N_CHECKS-1:0] odd;

  for (genvar r = 0; r < N_CHECKS; r++) begin : g_row
    assign odd[r] = ^(word & H_MAT[r*N_BITS +: N_BITS]);
  end

  assign zero = ~|odd;

endmodule

// File: rtl/ldpc_pipe_reg.sv
module ldpc_pipe_reg #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_data  <= in_data;
    end
  end

endmodule

// File: rtl/ldpc_bf_stage.sv
module ldpc_bf_stage #(
  parameter int N_BITS   = 6,
  parameter int N_CHECKS = 4,
  parameter logic [N_CHECKS*N_BITS-1:0] H_MAT = '0,
  parameter int IDX      = 0,
  parameter int TAG_W    = 2,
  parameter int NEVER    = 3
)(
  input  logic [N_BITS-1:0] in_word,
  input  logic [TAG_W-1:0]  in_tag,
  output logic [N_BITS-1:0] out_word,
  output logic [TAG_W-1:0]  out_tag
);

  localparam logic [TAG_W-1:0] NEVER_T = TAG_W'(NEVER);
  localparam logic [TAG_W-1:0] IDX_T   = TAG_W'(IDX);

  function automatic logic [N_CHECKS-1:0] col_of(int j);
    logic [N_CHECKS-1:0] c;
    for (int r = 0; r < N_CHECKS; r++) c[r] = H_MAT[r*N_BITS + j];
    return c;
  endfunction

  logic [N_BITS-1:0]   pred [N_CHECKS];
  logic [N_CHECKS-1:0] fails;

  for (genvar r = 0; r < N_CHECKS; r++) begin : g_chk
    ldpc_check_node #(
      .N_BITS (N_BITS),
      .ROW    (H_MAT[r*N_BITS +: N_BITS])
    ) u_chk (
      .word (in_word),
      .pred (pred[r]),
      .fail (fails[r])
    );
  end

  for (genvar j = 0; j < N_BITS; j++) begin : g_bit
    logic [N_CHECKS-1:0] col_pred;

    always_comb begin
      for (int r = 0; r < N_CHECKS; r++) col_pred[r] = pred[r][j];
    end

    ldpc_bit_node #(
      .N_CHECKS (N_CHECKS),
      .COL      (col_of(j))
    ) u_bit (
      .cur   (in_word[j]),
      .preds (col_pred),
      .nxt   (out_word[j])
    );
  end

  // The word entering this stage has seen IDX updates; record that count
  // if it is the first point where every check is satisfied.
  assign out_tag = ((in_tag == NEVER_T) && (fails == '0)) ? IDX_T : in_tag;

endmodule

// File: rtl/ldpc_bf_decoder.sv
module ldpc_bf_decoder
  import ldpc_bf_pkg::*;
#(
  parameter int N_BITS   = DEF_N_BITS,
  parameter int N_CHECKS = DEF_N_CHECKS,
  parameter logic [N_CHECKS*N_BITS-1:0] H_MAT = DEF_H_MAT,
  parameter int N_STAGES = DEF_N_STAGES,
  parameter logic [N_STAGES-1:0] REG_MASK = '1,
  localparam int TAG_W = $clog2(N_STAGES + 2)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [N_BITS-1:0] in_word,
  output logic              out_valid,
  output logic [N_BITS-1:0] out_word,
  output logic              out_syn_ok,
  output logic [TAG_W-1:0]  out_first_ok
);

  localparam int NEVER = N_STAGES + 1;
  localparam int PW    = TAG_W + N_BITS;
  localparam logic [TAG_W-1:0] NEVER_T = TAG_W'(NEVER);
  localparam logic [TAG_W-1:0] LAST_T  = TAG_W'(N_STAGES);

  logic [N_STAGES:0] v_c;
  logic [N_BITS-1:0] w_c [N_STAGES+1];
  logic [TAG_W-1:0]  t_c [N_STAGES+1];

  assign v_c[0] = in_valid;
  assign w_c[0] = in_word;
  assign t_c[0] = NEVER_T;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    logic [N_BITS-1:0] sw;
    logic [TAG_W-1:0]  st;

    ldpc_bf_stage #(
      .N_BITS   (N_BITS),
      .N_CHECKS (N_CHECKS),
      .H_MAT    (H_MAT),
      .IDX      (s),
      .TAG_W    (TAG_W),
      .NEVER    (NEVER)
    ) u_stage (
      .in_word  (w_c[s]),
      .in_tag   (t_c[s]),
      .out_word (sw),
      .out_tag  (st)
    );

    // The last stage always feeds the output register, so its mask bit is unused.
    if ((s < N_STAGES - 1) && REG_MASK[s]) begin : g_reg
      logic [PW-1:0] q;

      ldpc_pipe_reg #(
        .W (PW)
      ) u_reg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (v_c[s]),
        .in_data   ({st, sw}),
        .out_valid (v_c[s+1]),
        .out_data  (q)
      );

      assign w_c[s+1] = q[N_BITS-1:0];
      assign t_c[s+1] = q[PW-1:N_BITS];
    end else begin : g_thru
      assign v_c[s+1] = v_c[s];
      assign w_c[s+1] = sw;
      assign t_c[s+1] = st;
    end
  end

  logic             fin_zero;
  logic [TAG_W-1:0] fin_tag;

  ldpc_syndrome #(
    .N_BITS   (N_BITS),
    .N_CHECKS (N_CHECKS),
    .H_MAT    (H_MAT)
  ) u_final (
    .word (w_c[N_STAGES]),
    .zero (fin_zero)
  );

  assign fin_tag = ((t_c[N_STAGES] == NEVER_T) && fin_zero) ? LAST_T : t_c[N_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_word     <= '0;
      out_syn_ok   <= 1'b0;
      out_first_ok <= '0;
    end else begin
      out_valid    <= v_c[N_STAGES];
      out_word     <= w_c[N_STAGES];
      out_syn_ok   <= fin_zero;
      out_first_ok <= fin_tag;
    end
  end

endmodule

// File: rtl/ldpc_bf_checker.sv
module ldpc_bf_checker #(
  parameter int N_BITS   = 6,
  parameter int N_CHECKS = 4,
  parameter logic [N_CHECKS*N_BITS-1:0] H_MAT = '0,
  parameter int N_STAGES = 2,
  parameter logic [N_STAGES-1:0] REG_MASK = '1,
  parameter int TAG_W    = 2
)(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic [N_BITS-1:0] out_word,
  input logic              out_syn_ok,
  input logic [TAG_W-1:0]  out_first_ok
);

  function automatic int lat_of();
    int n = 1;
    for (int s = 0; s < N_STAGES - 1; s++) if (REG_MASK[s]) n++;
    return n;
  endfunction

  localparam int LAT = lat_of();
  localparam logic [TAG_W-1:0] NEVER_T = TAG_W'(N_STAGES + 1);

  logic [LAT-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe <= '0;
    end else begin
      vpipe[0] <= in_valid;
      for (int i = 1; i < LAT; i++) vpipe[i] <= vpipe[i-1];
    end
  end

  logic even_all;

  always_comb begin
    even_all = 1'b1;
    for (int r = 0; r < N_CHECKS; r++) begin
      if (^(out_word & H_MAT[r*N_BITS +: N_BITS])) even_all = 1'b0;
    end
  end

  // R7: output strobe follows the input strobe after the configured latency
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid == vpipe[LAT-1]);

  // R5: flag agrees with an independent parity test of the output word
  p_syn_word_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_syn_ok == even_all));

  // R6: the "never valid" tag appears exactly when the final check fails
  p_first_syn_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_syn_ok == (out_first_ok != NEVER_T)));

  // R6: tag stays inside its defined range
  p_first_range_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_first_ok <= NEVER_T));

  // R8: reset clears the output strobe on the next edge
  p_reset_r8: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

bind ldpc_bf_decoder ldpc_bf_checker #(
  .N_BITS   (N_BITS),
  .N_CHECKS (N_CHECKS),
  .H_MAT    (H_MAT),
  .N_STAGES (N_STAGES),
  .REG_MASK (REG_MASK),
  .TAG_W    (TAG_W)
) u_bf_checker (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .out_valid    (out_valid),
  .out_word     (out_word),
  .out_syn_ok   (out_syn_ok),
  .out_first_ok (out_first_ok)
);

// File: tb/tb_ldpc_bf_decoder.sv
module tb_ldpc_bf_decoder;

  localparam int NCYC  = 700;
  localparam int LAT_A = 2;   // 2 stages, both registered
  localparam int LAT_B = 1;   // 3 stages, no inter-stage register
  localparam int STG_A = 2;
  localparam int STG_B = 3;

  // Independent copy of the default matrix rows (R10).
  localparam logic [5:0] HR [4] = '{6'b001011, 6'b010110, 6'b110001, 6'b101100};

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [5:0] in_word;

  logic       a_valid, b_valid;
  logic [5:0] a_word,  b_word;
  logic       a_ok,    b_ok;
  logic [1:0] a_first;
  logic [2:0] b_first;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  logic [5:0] hw [0:NCYC-1];
  bit         hv [0:NCYC-1];

  always #10 clk = ~clk;   // 50 MHz

  ldpc_bf_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(a_valid), .out_word(a_word), .out_syn_ok(a_ok), .out_first_ok(a_first)
  );

  ldpc_bf_decoder #(.N_STAGES(STG_B), .REG_MASK(3'b000)) dut_b (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(b_valid), .out_word(b_word), .out_syn_ok(b_ok), .out_first_ok(b_first)
  );

  function automatic bit is_cw(logic [5:0] w);
    for (int c = 0; c < 4; c++) if (^(w & HR[c])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [5:0] step(logic [5:0] w);
    logic [5:0] r = w;
    for (int j = 0; j < 6; j++) begin
      int deg = 0;
      int dis = 0;
      for (int c = 0; c < 4; c++) begin
        if (HR[c][j]) begin
          logic p;
          deg++;
          p = ^(w & HR[c] & ~(6'b1 << j));
          if (p != w[j]) dis++;
        end
      end
      if (2 * dis > deg) r[j] = ~w[j];
    end
    return r;
  endfunction

  task automatic model(input logic [5:0] w0, input int stages,
                       output logic [5:0] wf, output bit ok, output int first);
    logic [5:0] w = w0;
    first = is_cw(w0) ? 0 : stages + 1;
    for (int k = 1; k <= stages; k++) begin
      w = step(w);
      if (first == stages + 1 && is_cw(w)) first = k;
    end
    wf = w;
    ok = is_cw(w);
  endtask

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    n_checks++;
    if (!good) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string word_tag(logic [5:0] w);
    if (w == 6'b110110) return "R9 example word";
    if (is_cw(w))       return "R4 codeword kept";
    if (w == 6'b000011) return "R2 tie keeps bits";
    return "R1 R3 majority update";
  endfunction

  task automatic compare(input string name, input int idx, input int stages,
                         input logic v, input logic [5:0] w, input logic ok,
                         input int first);
    logic [5:0] ew;
    bit eok;
    int efirst;
    if (!hv[idx]) begin
      chk(v == 1'b0, {name, " R7 idle valid"}, v, 0);
    end else begin
      model(hw[idx], stages, ew, eok, efirst);
      chk(v == 1'b1, {name, " R7 valid"}, v, 1);
      chk(w == ew, {name, " ", word_tag(hw[idx])}, w, ew);
      chk(ok == eok, {name, " R5 R10 syndrome"}, ok, eok);
      chk(first == efirst, {name, " R6 first tag"}, first, efirst);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual running expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst      = 1'b1;
    in_valid = 1'b0;
    in_word  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R8: reset state
    chk(a_valid == 0, "R8 reset valid A", a_valid, 0);
    chk(a_word == 0,  "R8 reset word A", a_word, 0);
    chk(a_ok == 0,    "R8 reset syn A", a_ok, 0);
    chk(a_first == 0, "R8 reset tag A", a_first, 0);
    chk(b_valid == 0, "R8 reset valid B", b_valid, 0);
    chk(b_first == 0, "R8 reset tag B", b_first, 0);

    rst = 1'b0;
    for (int i = 0; i < NCYC; i++) begin
      if (i >= LAT_A) compare("A", i - LAT_A, STG_A, a_valid, a_word, a_ok, int'(a_first));
      if (i >= LAT_B) compare("B", i - LAT_B, STG_B, b_valid, b_word, b_ok, int'(b_first));

      case (i)
        0:  begin hv[i] = 1; hw[i] = 6'b110110; end  // R9 example
        1:  begin hv[i] = 1; hw[i] = 6'b000000; end  // R4 zero codeword
        2:  begin hv[i] = 1; hw[i] = 6'b110100; end  // R4 nonzero codeword
        3:  begin hv[i] = 1; hw[i] = 6'b000011; end  // R2 double error, ties
        4:  begin hv[i] = 0; hw[i] = 6'b111111; end  // R7 idle slot
        5:  begin hv[i] = 1; hw[i] = 6'b111111; end
        6:  begin hv[i] = 1; hw[i] = 6'b100100; end  // R1 single error
        7:  begin hv[i] = 0; hw[i] = 6'b000000; end
        default: begin
          hv[i] = ($urandom % 4) != 0;
          hw[i] = 6'($urandom);
        end
      endcase
      in_valid = hv[i];
      in_word  = hw[i];
      @(negedge clk);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule